// File: doc/BRIEF.md
# Set/Clear Inter-Core Mailbox Bank

This block holds sixteen 32-bit mailboxes that cores use to signal one another. There are four cores and each owns four mailboxes. Each mailbox has two word addresses. A write to its set address ORs the written word into the mailbox. A write to its clear address removes every bit that is 1 in the written word. The clear address also reads the mailbox back. Several senders can therefore post flags into the same mailbox, and the owner can retire exactly the flags it has handled, with no read-modify-write race.

Requests arrive on a valid/ready channel that carries a write flag, a byte offset and write data. Reads answer on a valid/ready response channel, with at most one response outstanding. `req_ready` is low while a response is waiting and `rsp_ready` is low, so every request (write or read) stalls until the waiting response is taken. The response stays stable until it is taken. Writes produce no response.

Each mailbox drives a pending flag that feeds an interrupt router outside this block. The flag is high whenever the mailbox holds any nonzero bit.

Top module: `mbx_bank`

## Requirements
- R1: After reset every mailbox holds zero, `mbx_pending` is all zero, `rsp_valid` is low and `req_ready` is high.
- R2: An accepted write to byte offset 0x80 + 4*m (m = 0..15) ORs `req_wdata` into mailbox m and leaves the other mailboxes unchanged.
- R3: An accepted write to byte offset 0xC0 + 4*m clears each bit of mailbox m that is 1 in `req_wdata`, and leaves all other bits and mailboxes unchanged.
- R4: An accepted read of offset 0xC0 + 4*m raises `rsp_valid` in the next cycle, and `rsp_rdata` then holds mailbox m as it stood when the read was accepted. An accepted write never raises `rsp_valid`.
- R5: A read of the set window (0x80..0xBF) or of any offset outside 0x80..0xFF returns zero. A write outside 0x80..0xFF changes no mailbox.
- R6: `mbx_pending[m]` is 1 exactly when mailbox m is nonzero. It changes in the cycle after the write that changes the mailbox. Bit m belongs to core m/4 as that core's local mailbox m%4.
- R7: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_rdata` hold their values and `req_ready` is low. A request takes effect only on a cycle where `req_valid` and `req_ready` are both high.
- R8: Offset bits [1:0] are ignored, so every byte offset inside a word selects that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset |
| req_wdata | input | 32 | Write data: set bits or clear mask |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Read data |
| mbx_pending | output | 16 | Per-mailbox nonzero flag, bit 4*core+local |

## Verification
The hardest case to reach is a read response held under back-pressure while the bank keeps state. The bench must show that the held data does not change and that no request slips through, even though the sender is still presenting one. The stimulus drops `rsp_ready` at random for several cycles after reads, while writes to the same mailbox wait at the request port. Random set and clear traffic with sparse, one-hot and full masks, sent at misaligned byte offsets, walks the mailboxes through partial clears. The pending flag is compared to a bench model after every request.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // Kind of window a byte offset falls into
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_SET  = 2'd1,
    WIN_CLR  = 2'd2
  } mbx_win_e;
endpackage

// File: rtl/mbx_addr_dec.sv
module mbx_addr_dec
  import mbx_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_MBX  = 16,
  parameter int SET_BASE = 'h80,
  parameter int CLR_BASE = 'hC0,
  localparam int IDX_W   = $clog2(NUM_MBX)
) (
  input  logic               accept,
  input  logic               write,
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_MBX-1:0] set_vec,
  output logic [NUM_MBX-1:0] clr_vec,
  output logic               rd_hit,
  output logic [IDX_W-1:0]   rd_idx
);
  localparam int WIN_BYTES = NUM_MBX * 4;

  mbx_win_e          win;
  logic [ADDR_W-1:0] set_off;
  logic [ADDR_W-1:0] clr_off;
  logic [IDX_W-1:0]  set_idx;
  logic [IDX_W-1:0]  clr_idx;

  always_comb begin
    set_off = addr - ADDR_W'(SET_BASE);
    clr_off = addr - ADDR_W'(CLR_BASE);
    // dropping the two low bits ignores byte lanes within a word
    set_idx = IDX_W'(set_off >> 2);
    clr_idx = IDX_W'(clr_off >> 2);
    if (int'(addr) >= SET_BASE && int'(addr) < SET_BASE + WIN_BYTES)
      win = WIN_SET;
    else if (int'(addr) >= CLR_BASE && int'(addr) < CLR_BASE + WIN_BYTES)
      win = WIN_CLR;
    else
      win = WIN_NONE;
  end

  for (genvar i = 0; i < NUM_MBX; i++) begin : g_sel
    assign set_vec[i] = accept && write && (win == WIN_SET) && (set_idx == IDX_W'(i));
    assign clr_vec[i] = accept && write && (win == WIN_CLR) && (clr_idx == IDX_W'(i));
  end

  assign rd_hit = (win == WIN_CLR);
  assign rd_idx = clr_idx;
endmodule

// File: rtl/mbx_cell.sv
module mbx_cell #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q,
  output logic              pend
);
  logic [DATA_W-1:0] set_bits;
  logic [DATA_W-1:0] clr_bits;
  logic [DATA_W-1:0] q_nxt;

  always_comb begin
    set_bits = set_en ? wdata : '0;
    clr_bits = clr_en ? wdata : '0;
    // clear is applied on top of any set
    q_nxt    = (q | set_bits) & ~clr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  assign pend = |q;

  // R2
  set_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en && !clr_en |=> ((q & $past(wdata)) == $past(wdata)));
  // R3
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((q & $past(wdata)) == '0));
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !set_en && !clr_en |=> $stable(q));
endmodule

// File: rtl/mbx_rdmux.sv
module mbx_rdmux #(
  parameter int DATA_W  = 32,
  parameter int NUM_MBX = 16,
  localparam int IDX_W  = $clog2(NUM_MBX)
) (
  input  logic [DATA_W-1:0] mbox [NUM_MBX],
  input  logic              hit,
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_MBX; i++) begin
      if (hit && idx == IDX_W'(i)) rdata = mbox[i];
    end
  end
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank #(
  parameter int NUM_CORES    = 4,
  parameter int MBX_PER_CORE = 4,
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 8,
  parameter int SET_BASE     = 'h80,
  parameter int CLR_BASE     = 'hC0,
  localparam int NUM_MBX     = NUM_CORES * MBX_PER_CORE,
  localparam int IDX_W       = $clog2(NUM_MBX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic [NUM_MBX-1:0] mbx_pending
);
  logic               accept;
  logic [NUM_MBX-1:0] set_vec;
  logic [NUM_MBX-1:0] clr_vec;
  logic               rd_hit;
  logic [IDX_W-1:0]   rd_idx;
  logic [DATA_W-1:0]  rd_data;
  logic [DATA_W-1:0]  mbox_q [NUM_MBX];

  assign req_ready = rst_n && (!rsp_valid || rsp_ready);
  assign accept    = req_valid && req_ready;

  mbx_addr_dec #(
    .ADDR_W   (ADDR_W),
    .NUM_MBX  (NUM_MBX),
    .SET_BASE (SET_BASE),
    .CLR_BASE (CLR_BASE)
  ) u_dec (
    .accept  (accept),
    .write   (req_write),
    .addr    (req_addr),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .rd_hit  (rd_hit),
    .rd_idx  (rd_idx)
  );

  // pending bit index = core*MBX_PER_CORE + local index
  for (genvar m = 0; m < NUM_MBX; m++) begin : g_mbx
    mbx_cell #(.DATA_W(DATA_W)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (set_vec[m]),
      .clr_en (clr_vec[m]),
      .wdata  (req_wdata),
      .q      (mbox_q[m]),
      .pend   (mbx_pending[m])
    );

    // R6
    pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mbx_pending[m]) |-> $past(set_vec[m]));
  end

  mbx_rdmux #(.DATA_W(DATA_W), .NUM_MBX(NUM_MBX)) u_rdmux (
    .mbox  (mbox_q),
    .hit   (rd_hit),
    .idx   (rd_idx),
    .rdata (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= !req_write;
      if (!req_write) rsp_rdata <= rd_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R4
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !req_write |=> rsp_valid);
  // R4
  wr_no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_write |=> !rsp_valid);
  // R7
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));
endmodule

// File: tb/mbx_bank_test.sv
`timescale 1ns/1ps
module mbx_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic [15:0] mbx_pending;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [31:0] mdl [16];

  always #2.5 clk = ~clk;

  mbx_bank uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .mbx_pending(mbx_pending)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (a >= 8'hC0) return mdl[(a - 8'hC0) >> 2];
    return 32'h0;
  endfunction

  function automatic logic [15:0] exp_pend();
    logic [15:0] p;
    for (int i = 0; i < 16; i++) p[i] = (mdl[i] != 0);
    return p;
  endfunction

  // present one request; returns after the accepting edge
  task automatic issue(input bit wr, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #0.5;
    req_valid = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d, input string tag);
    issue(1'b1, a, d);
    if (a >= 8'h80 && a < 8'hC0) mdl[(a - 8'h80) >> 2] |= d;
    else if (a >= 8'hC0) mdl[(a - 8'hC0) >> 2] &= ~d;
    @(negedge clk);
    chk(mbx_pending == exp_pend(), {tag, " R6 pending"}, {16'h0, mbx_pending}, {16'h0, exp_pend()});
    chk(rsp_valid == 1'b0, "R4 write gave no response", {31'h0, rsp_valid}, 32'h0);
  endtask

  task automatic do_read(input logic [7:0] a, input string tag, input bit stall);
    logic [31:0] e;
    logic [31:0] first;
    e = exp_read(a);
    issue(1'b0, a, 32'h0);
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R4 read response valid", {31'h0, rsp_valid}, 32'h1);
    first = rsp_rdata;
    chk(rsp_rdata == e, tag, rsp_rdata, e);
    if (stall) begin
      rsp_ready = 1'b0;
      // sender still presents a write to the same mailbox: must not be taken
      req_valid = 1'b1; req_write = 1'b1;
      req_addr = (a >= 8'hC0) ? a - 8'h40 : a; req_wdata = 32'hFFFF_FFFF;
      repeat (1 + $urandom % 4) begin
        @(negedge clk);
        chk(req_ready == 1'b0 && rsp_valid == 1'b1 && rsp_rdata == first,
            "R7 held response / stalled request", rsp_rdata, first);
      end
      req_valid = 1'b0;
      rsp_ready = 1'b1;
      @(negedge clk);
      chk(mbx_pending == exp_pend(), "R7 stalled write had no effect", {16'h0, mbx_pending}, {16'h0, exp_pend()});
    end else begin
      @(negedge clk);
    end
    chk(rsp_valid == 1'b0, "R7 response released", {31'h0, rsp_valid}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  a;
    logic [31:0] d;
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mbx_pending == 16'h0 && rsp_valid == 1'b0, "R1 reset state", {15'h0, rsp_valid, mbx_pending}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", {31'h0, req_ready}, 32'h1);
    for (int m = 0; m < 16; m++) do_read(8'hC0 + 8'(4 * m), "R1 mailbox zero", 1'b0);

    // directed corners
    do_write(8'h80, 32'h0000_0001, "R2 set mbox0");
    do_write(8'h80, 32'h8000_0000, "R2 or mbox0");
    do_read(8'hC0, "R2 mbox0 accumulated", 1'b0);
    do_write(8'hBC, 32'hFFFF_FFFF, "R2 set mbox15");
    do_write(8'hFC, 32'h0, "R3 clear with zero mask");
    do_read(8'hFE, "R8 misaligned read mbox15", 1'b0);
    do_write(8'hFF, 32'h0F0F_0F0F, "R3 R8 partial clear mbox15");
    do_read(8'hFC, "R3 mbox15 after partial clear", 1'b1);
    do_read(8'hBC, "R5 set window reads zero", 1'b0);
    do_write(8'h40, 32'hFFFF_FFFF, "R5 write outside windows");
    do_read(8'h40, "R5 outside read zero", 1'b0);
    do_write(8'hC0, 32'hFFFF_FFFF, "R3 full clear mbox0");
    do_write(8'h9D, 32'h0000_0100, "R8 R6 core1 local3");
    do_read(8'hDC, "R6 R2 mbox7", 1'b1);

    // random traffic
    for (int n = 0; n < 400; n++) begin
      int k;
      k = $urandom % 6;
      case ($urandom % 3)
        0: d = $urandom;
        1: d = 32'h1 << ($urandom % 32);
        default: d = 32'hFFFF_FFFF;
      endcase
      a = 8'(4 * ($urandom % 16) + ($urandom % 4));
      case (k)
        0, 1: do_write(8'h80 + a, d, "R2 random set");
        2:    do_write(8'hC0 + a, d, "R3 random clear");
        3:    do_read(8'hC0 + a, "R4 random read", $urandom % 2 == 1);
        4:    do_read(8'h80 + a, "R5 random set-window read", 1'b0);
        default: begin
          a = 8'($urandom % 128);
          if ($urandom % 2 == 1) do_write(a, d, "R5 random outside write");
          else do_read(a, "R5 random outside read", 1'b0);
        end
      endcase
    end
    for (int m = 0; m < 16; m++) do_read(8'hC0 + 8'(4 * m), "R4 final contents", 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule